// File: doc/BRIEF.md
# Timestamp-Matched Event Builder

This block gathers hit packets from several independent front-end sources and groups them into events by their timestamp. Each incoming packet carries a 24-bit timestamp, a 16-bit source address and a 64-bit hit pattern. Consecutive packets that share a timestamp are written into the same event buffer in arrival order. A buffer stops taking packets, and is offered to the host as one complete unit, when a packet with another timestamp arrives or when a programmable number of cycles passes with no input at all.

Several event buffers are used in turn, so one buffer can fill while the host reads another. The host reads any word of a buffer through a simple indexed read port with one cycle of latency. It returns a buffer to the free pool by pulsing an acknowledge with the buffer number. A packet that finds no room is discarded. Running counts of received packets, closed events and discarded packets, and a sticky overflow flag, are available to the host as outputs.

Top module: `eb_event_builder`

## Requirements
- R1: After a synchronous reset every `buf_ready` bit is 0, the three counters read 0 and `ovf_sticky` is 0.
- R2: Packets with equal timestamps that arrive in consecutive accepted slots go into one buffer in arrival order; word k (k >= 1) of the buffer holds the k-th packet as {ts in bits 103:80, address in bits 79:64, hits in bits 63:0}.
- R3: A packet whose timestamp differs from the open event closes that event: its `buf_ready` bit is 1 after the same clock edge that takes the new packet, and word 0 of the buffer reads {timestamp in bits 103:80, zeros in bits 79:16, packet count in bits 15:0}.
- R4: With `cfg_timeout` = T (0 acts as 1), an open event closes at the T-th clock edge after its last input packet when no packet arrives in between; before that edge its `buf_ready` bit stays 0.
- R5: A new event takes the lowest-numbered free buffer, so with two buffers events alternate between them while the host keeps up.
- R6: A packet that opens a new event while no buffer is free is discarded, `cnt_drop` increments and `ovf_sticky` becomes 1 and stays 1 until reset.
- R7: Once an event holds DEPTH packets, further packets with the same timestamp are discarded and counted in `cnt_drop`; the buffer keeps the first DEPTH packets.
- R8: A buffer whose `buf_ready` bit is 1 is returned to the free pool only by `host_ack` with `host_ack_buf` naming it; its bit is 0 after that edge and until then it is never reused.
- R9: A read request on `host_rd_en` gives `host_rd_valid` = 1 and the addressed word on `host_rd_data` after the next clock edge.
- R10: `cnt_rx` counts every input packet, accepted or not, and `cnt_events` counts every closed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Input packet present this cycle |
| pkt_ts | input | 24 | Packet timestamp |
| pkt_addr | input | 16 | Packet source address |
| pkt_hits | input | 64 | Packet hit pattern |
| cfg_timeout | input | TO_W | Idle cycles before an open event closes |
| host_ack | input | 1 | Release the buffer named by host_ack_buf |
| host_ack_buf | input | BUF_W | Buffer to release |
| host_rd_en | input | 1 | Read request |
| host_rd_buf | input | BUF_W | Buffer to read |
| host_rd_word | input | IDX_W | Word to read: 0 header, k packet k |
| host_rd_valid | output | 1 | Read data valid |
| host_rd_data | output | 104 | Read data |
| buf_ready | output | NUM_BUF | One bit per buffer holding a closed event |
| cnt_rx | output | CNT_W | Packets received |
| cnt_events | output | CNT_W | Events closed |
| cnt_drop | output | CNT_W | Packets discarded |
| ovf_sticky | output | 1 | A packet has been discarded since reset |

## Verification
A wrong buffer state shows first on `buf_ready` and `cnt_events` one edge after the packet or idle period that should close an event, and the header word read two edges later exposes a wrong count or timestamp. A wrong allocation or write index is seen only when the host reads packet words back, so each stored word is compared with the packet that was sent. Timeout errors are caught by sampling `buf_ready` on the edge before and the edge of the expected expiry, and drop errors by the drop counter and the overflow flag on the edge after the discarded packet.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int TS_W   = 24;
  localparam int ADDR_W = 16;
  localparam int HIT_W  = 64;
  localparam int PKT_W  = TS_W + ADDR_W + HIT_W;
  localparam int HCNT_W = 16;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [ADDR_W-1:0] addr;
    logic [HIT_W-1:0]  hits;
  } eb_pkt_t;
endpackage

// File: rtl/eb_timeout.sv
module eb_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            armed,
  input  logic            activity,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] idle_q;
  logic [TO_W:0]   idle_nxt;

  always_comb begin
    idle_nxt = {1'b0, idle_q} + 1'b1;
    expire   = armed && !activity && (idle_nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || activity || expire) idle_q <= '0;
    else                                     idle_q <= idle_nxt[TO_W-1:0];
  end

  AST_IDLE_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((idle_q < limit) || (idle_q == '0))); // R4
endmodule

// File: rtl/eb_store.sv
module eb_store #(
  parameter int WIDTH = 104,
  parameter int WORDS = 16,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/eb_counters.sv
module eb_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_rx,
  input  logic             inc_evt,
  input  logic             inc_drop,
  output logic [CNT_W-1:0] cnt_rx,
  output logic [CNT_W-1:0] cnt_evt,
  output logic [CNT_W-1:0] cnt_drop,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_rx   <= '0;
      cnt_evt  <= '0;
      cnt_drop <= '0;
      ovf      <= 1'b0;
    end else begin
      if (inc_rx)   cnt_rx   <= cnt_rx + 1'b1;
      if (inc_evt)  cnt_evt  <= cnt_evt + 1'b1;
      if (inc_drop) begin
        cnt_drop <= cnt_drop + 1'b1;
        ovf      <= 1'b1;
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R6
  AST_DROP_RAISES_OVF: assert property (@(posedge clk) disable iff (rst)
    inc_drop |=> ovf); // R6
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl import eb_pkg::*; #(
  parameter int NUM_BUF = 2,
  parameter int DEPTH   = 8,
  localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              pkt_valid,
  input  logic [TS_W-1:0]                   pkt_ts,
  input  logic                              expire,
  input  logic                              ack,
  input  logic [BUF_W-1:0]                  ack_buf,
  output logic                              open_o,
  output logic                              wr_en,
  output logic [BUF_W-1:0]                  wr_buf,
  output logic [IDX_W-1:0]                  wr_idx,
  output logic                              close_o,
  output logic                              drop_o,
  output logic [NUM_BUF-1:0]                rdy_o,
  output logic [NUM_BUF-1:0][TS_W-1:0]      hdr_ts,
  output logic [NUM_BUF-1:0][IDX_W-1:0]     hdr_cnt
);
  logic                 open_q;
  logic [BUF_W-1:0]     cur_buf_q;
  logic [TS_W-1:0]      cur_ts_q;
  logic [IDX_W-1:0]     cur_cnt_q;
  logic [NUM_BUF-1:0]   busy_q;
  logic [NUM_BUF-1:0]   rdy_q;

  logic             have_free;
  logic [BUF_W-1:0] pick;
  logic             same_ts;
  logic             has_room;
  logic             open_new;
  logic             accept;

  // lowest-numbered free buffer wins
  always_comb begin
    have_free = 1'b0;
    pick      = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        have_free = 1'b1;
        pick      = BUF_W'(i);
      end
    end
  end

  always_comb begin
    same_ts  = open_q && (pkt_ts == cur_ts_q);
    has_room = cur_cnt_q < IDX_W'(DEPTH);
    close_o  = open_q && (pkt_valid ? !same_ts : expire);
    open_new = pkt_valid && !same_ts && have_free;
    accept   = same_ts ? (pkt_valid && has_room) : open_new;
    drop_o   = pkt_valid && !accept;
    wr_en    = accept;
    wr_buf   = same_ts ? cur_buf_q : pick;
    wr_idx   = same_ts ? cur_cnt_q : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      cur_buf_q <= '0;
      cur_ts_q  <= '0;
      cur_cnt_q <= '0;
      busy_q    <= '0;
      rdy_q     <= '0;
      hdr_ts    <= '0;
      hdr_cnt   <= '0;
    end else begin
      if (close_o) begin
        rdy_q[cur_buf_q]   <= 1'b1;
        hdr_ts[cur_buf_q]  <= cur_ts_q;
        hdr_cnt[cur_buf_q] <= cur_cnt_q;
        open_q             <= 1'b0;
      end
      if (open_new) begin
        open_q       <= 1'b1;
        cur_buf_q    <= pick;
        cur_ts_q     <= pkt_ts;
        cur_cnt_q    <= IDX_W'(1);
        busy_q[pick] <= 1'b1;
      end else if (accept) begin
        cur_cnt_q <= cur_cnt_q + 1'b1;
      end
      if (ack && rdy_q[ack_buf]) begin
        rdy_q[ack_buf]  <= 1'b0;
        busy_q[ack_buf] <= 1'b0;
      end
    end
  end

  assign open_o = open_q;
  assign rdy_o  = rdy_q;

  AST_READY_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rdy_q & ~busy_q) == '0); // R8
  AST_OPEN_BUF_FILLING: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (busy_q[cur_buf_q] && !rdy_q[cur_buf_q])); // R5
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cur_cnt_q <= IDX_W'(DEPTH)); // R7
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (ack && rdy_q[ack_buf]) |=> !rdy_q[$past(ack_buf)]); // R8
endmodule

// File: rtl/eb_event_builder.sv
module eb_event_builder import eb_pkg::*; #(
  parameter int NUM_BUF  = 2,
  parameter int DEPTH    = 8,
  parameter int TO_W     = 16,
  parameter int CNT_W    = 16,
  localparam int BUF_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int IDX_W   = $clog2(DEPTH + 1),
  localparam int MEM_WDS = NUM_BUF * DEPTH,
  localparam int MA_W    = (MEM_WDS > 1) ? $clog2(MEM_WDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_valid,
  input  logic [TS_W-1:0]    pkt_ts,
  input  logic [ADDR_W-1:0]  pkt_addr,
  input  logic [HIT_W-1:0]   pkt_hits,
  input  logic [TO_W-1:0]    cfg_timeout,
  input  logic               host_ack,
  input  logic [BUF_W-1:0]   host_ack_buf,
  input  logic               host_rd_en,
  input  logic [BUF_W-1:0]   host_rd_buf,
  input  logic [IDX_W-1:0]   host_rd_word,
  output logic               host_rd_valid,
  output logic [PKT_W-1:0]   host_rd_data,
  output logic [NUM_BUF-1:0] buf_ready,
  output logic [CNT_W-1:0]   cnt_rx,
  output logic [CNT_W-1:0]   cnt_events,
  output logic [CNT_W-1:0]   cnt_drop,
  output logic               ovf_sticky
);
  logic                           open_w;
  logic                           expire_w;
  logic                           wr_en_w;
  logic [BUF_W-1:0]               wr_buf_w;
  logic [IDX_W-1:0]               wr_idx_w;
  logic                           close_w;
  logic                           drop_w;
  logic [NUM_BUF-1:0][TS_W-1:0]   hdr_ts_w;
  logic [NUM_BUF-1:0][IDX_W-1:0]  hdr_cnt_w;
  logic [MA_W-1:0]                waddr;
  logic [MA_W-1:0]                raddr;
  logic                           mem_re;
  logic [PKT_W-1:0]               mem_q;
  logic [PKT_W-1:0]               hdr_q;
  logic                           hdr_sel_q;
  eb_pkt_t                        wpkt;

  always_comb begin
    wpkt.ts   = pkt_ts;
    wpkt.addr = pkt_addr;
    wpkt.hits = pkt_hits;
    waddr  = MA_W'(32'(wr_buf_w) * DEPTH + 32'(wr_idx_w));
    raddr  = MA_W'(32'(host_rd_buf) * DEPTH + 32'(host_rd_word) - 1);
    mem_re = host_rd_en && (host_rd_word != '0);
  end

  eb_timeout #(.TO_W(TO_W)) u_timeout (
    .clk(clk), .rst(rst), .armed(open_w), .activity(pkt_valid),
    .limit(cfg_timeout), .expire(expire_w)
  );

  eb_ctrl #(.NUM_BUF(NUM_BUF), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ts(pkt_ts),
    .expire(expire_w), .ack(host_ack), .ack_buf(host_ack_buf),
    .open_o(open_w), .wr_en(wr_en_w), .wr_buf(wr_buf_w), .wr_idx(wr_idx_w),
    .close_o(close_w), .drop_o(drop_w), .rdy_o(buf_ready),
    .hdr_ts(hdr_ts_w), .hdr_cnt(hdr_cnt_w)
  );

  eb_store #(.WIDTH(PKT_W), .WORDS(MEM_WDS)) u_store (
    .clk(clk), .we(wr_en_w), .waddr(waddr), .wdata(wpkt),
    .re(mem_re), .raddr(raddr), .rdata(mem_q)
  );

  eb_counters #(.CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst(rst), .inc_rx(pkt_valid), .inc_evt(close_w),
    .inc_drop(drop_w), .cnt_rx(cnt_rx), .cnt_evt(cnt_events),
    .cnt_drop(cnt_drop), .ovf(ovf_sticky)
  );

  // header word is assembled from the registered per-buffer descriptors
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rd_valid <= 1'b0;
      hdr_sel_q     <= 1'b0;
      hdr_q         <= '0;
    end else begin
      host_rd_valid <= host_rd_en;
      if (host_rd_en) begin
        hdr_sel_q <= (host_rd_word == '0);
        hdr_q     <= {hdr_ts_w[host_rd_buf], {(PKT_W-TS_W-HCNT_W){1'b0}},
                      HCNT_W'(hdr_cnt_w[host_rd_buf])};
      end
    end
  end

  assign host_rd_data = hdr_sel_q ? hdr_q : mem_q;

  AST_CLOSE_MARKS_READY: assert property (@(posedge clk) disable iff (rst)
    close_w |=> (buf_ready != '0)); // R3
endmodule

// File: tb/sim_eb_event_builder.sv
`timescale 1ns/1ps
module sim_eb_event_builder;
  localparam int NB = 2;
  localparam int DP = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pkt_valid = 1'b0;
  logic [23:0]  pkt_ts = '0;
  logic [15:0]  pkt_addr = '0;
  logic [63:0]  pkt_hits = '0;
  logic [15:0]  cfg_timeout = 16'd5;
  logic         host_ack = 1'b0;
  logic [0:0]   host_ack_buf = '0;
  logic         host_rd_en = 1'b0;
  logic [0:0]   host_rd_buf = '0;
  logic [3:0]   host_rd_word = '0;
  logic         host_rd_valid;
  logic [103:0] host_rd_data;
  logic [1:0]   buf_ready;
  logic [15:0]  cnt_rx, cnt_events, cnt_drop;
  logic         ovf_sticky;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  eb_event_builder #(.NUM_BUF(NB), .DEPTH(DP), .TO_W(16), .CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ts(pkt_ts),
    .pkt_addr(pkt_addr), .pkt_hits(pkt_hits), .cfg_timeout(cfg_timeout),
    .host_ack(host_ack), .host_ack_buf(host_ack_buf),
    .host_rd_en(host_rd_en), .host_rd_buf(host_rd_buf),
    .host_rd_word(host_rd_word), .host_rd_valid(host_rd_valid),
    .host_rd_data(host_rd_data), .buf_ready(buf_ready), .cnt_rx(cnt_rx),
    .cnt_events(cnt_events), .cnt_drop(cnt_drop), .ovf_sticky(ovf_sticky)
  );

  always #2.5 clk = ~clk;

  // stimulus table: {ts, addr, expected buffer (3 = dropped), expected word}
  localparam logic [45:0] VEC [6] = '{
    {24'h000100, 16'h0011, 2'd0, 4'd1},
    {24'h000100, 16'h0022, 2'd0, 4'd2},
    {24'h000100, 16'h0033, 2'd0, 4'd3},
    {24'h000200, 16'h0044, 2'd1, 4'd1},
    {24'h000200, 16'h0055, 2'd1, 4'd2},
    {24'h000300, 16'h0066, 2'd3, 4'd0}
  };

  function automatic logic [63:0] hits_of(logic [23:0] ts, logic [15:0] a);
    return {a, ts[15:0], ~a, 8'hA5, ts[7:0]};
  endfunction

  function automatic logic [103:0] pkt_word(logic [23:0] ts, logic [15:0] a);
    return {ts, a, hits_of(ts, a)};
  endfunction

  function automatic logic [103:0] hdr_word(logic [23:0] ts, int cnt);
    return {ts, 64'd0, 16'(cnt)};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [103:0] act, input logic [103:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // called at a negedge, returns at the negedge after the accepting edge
  task automatic send(input logic [23:0] ts, input logic [15:0] a);
    pkt_valid = 1'b1;
    pkt_ts    = ts;
    pkt_addr  = a;
    pkt_hits  = hits_of(ts, a);
    @(negedge clk);
  endtask

  task automatic read_word(input int b, input int w, input logic [103:0] exp,
                           input string req);
    host_rd_en   = 1'b1;
    host_rd_buf  = 1'(b);
    host_rd_word = 4'(w);
    @(negedge clk);
    check(host_rd_valid === 1'b1, "R9", 104'(host_rd_valid), 104'd1);
    check(host_rd_data === exp, req, host_rd_data, exp);
    host_rd_en = 1'b0;
  endtask

  task automatic ack(input int b);
    host_ack     = 1'b1;
    host_ack_buf = 1'(b);
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(buf_ready == 2'b00, "R1", 104'(buf_ready), 104'd0);
    check(cnt_rx == 0 && cnt_events == 0 && cnt_drop == 0, "R1",
          104'({cnt_rx, cnt_events, cnt_drop}), 104'd0);
    check(ovf_sticky == 1'b0, "R1", 104'(ovf_sticky), 104'd0);

    for (int i = 0; i < 6; i++) send(VEC[i][45:22], VEC[i][21:6]);
    pkt_valid = 1'b0;

    check(buf_ready == 2'b11, "R3", 104'(buf_ready), 104'd3);
    check(cnt_rx == 16'd6, "R10", 104'(cnt_rx), 104'd6);
    check(cnt_events == 16'd2, "R10", 104'(cnt_events), 104'd2);
    check(cnt_drop == 16'd1, "R6", 104'(cnt_drop), 104'd1);
    check(ovf_sticky == 1'b1, "R6", 104'(ovf_sticky), 104'd1);

    for (int i = 0; i < 6; i++) begin
      if (VEC[i][5:4] != 2'd3)
        read_word(int'(VEC[i][5:4]), int'(VEC[i][3:0]),
                  pkt_word(VEC[i][45:22], VEC[i][21:6]), "R2");
    end
    read_word(0, 0, hdr_word(24'h000100, 3), "R3");
    read_word(1, 0, hdr_word(24'h000200, 2), "R3");

    // R8: release only buffer 0
    ack(0);
    check(buf_ready == 2'b10, "R8", 104'(buf_ready), 104'd2);
    check(ovf_sticky == 1'b1, "R6", 104'(ovf_sticky), 104'd1);

    // R4: single packet then idle; R5 lowest free buffer is 0
    send(24'h000400, 16'h0077);
    pkt_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(buf_ready == 2'b10, "R4", 104'(buf_ready), 104'd2);
    @(negedge clk);
    check(buf_ready == 2'b11, "R4", 104'(buf_ready), 104'd3);
    check(cnt_events == 16'd3, "R10", 104'(cnt_events), 104'd3);
    read_word(0, 1, pkt_word(24'h000400, 16'h0077), "R5");
    read_word(0, 0, hdr_word(24'h000400, 1), "R4");

    // R7: fill buffer past its depth
    ack(0);
    ack(1);
    check(buf_ready == 2'b00, "R8", 104'(buf_ready), 104'd0);
    for (int k = 0; k <= DP; k++) send(24'h000500, 16'(16'h0100 + k));
    pkt_valid = 1'b0;
    check(cnt_drop == 16'd2, "R7", 104'(cnt_drop), 104'd2);
    repeat (5) @(negedge clk);
    check(buf_ready == 2'b01, "R7", 104'(buf_ready), 104'd1);
    read_word(0, 0, hdr_word(24'h000500, DP), "R7");
    read_word(0, 1, pkt_word(24'h000500, 16'h0100), "R7");
    read_word(0, DP, pkt_word(24'h000500, 16'(16'h0100 + DP - 1)), "R7");
    check(cnt_rx == 16'd16, "R10", 104'(cnt_rx), 104'd16);

    // R5: next event goes to the other buffer
    send(24'h000600, 16'h0099);
    pkt_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(buf_ready == 2'b11, "R5", 104'(buf_ready), 104'd3);
    read_word(1, 1, pkt_word(24'h000600, 16'h0099), "R5");
    read_word(1, 0, hdr_word(24'h000600, 1), "R5");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule